// File: doc/BRIEF.md
# Converter Result Output Port

This block is the host-facing output stage of a sampling converter. A conversion core, not part of this block, signals the start of a conversion and later hands over a result word with a one-cycle done strobe. The block stores that word and raises a busy flag while a conversion is in progress. It presents the stored result to a host through one of two paths. The parallel path is a full-width data bus, with its byte lanes optionally reversed so that a byte-wide host can fetch the two halves. The serial path is a one-bit stream, most significant bit first, advanced by a clock that the host supplies.

The host selects the block with an active-low chip select and an active-low read strobe. A mode input chooses between parallel and serial. A coding input chooses between straight (offset) binary and two's complement. The host serial clock is oversampled on the system clock, so that clock may run continuously or stop between words while idling either high or low.

Top module: `adc_result_port`

## Requirements
- R1: When `cs_n` or `rd_n` is high, `dbus_oe` and `sdata_oe` are all zero, and `dbus` and `sdata` are driven to zero.
- R2: With both `cs_n` and `rd_n` low, `ser_mode`=0 sets every bit of `dbus_oe` and clears `sdata_oe`, while `ser_mode`=1 sets `sdata_oe` and clears every bit of `dbus_oe`.
- R3: In parallel mode with `swap_bytes`=0, `dbus` equals the coded word. With `swap_bytes`=1, bits [7:0] and bits [15:8] of the coded word trade places on `dbus`.
- R4: The coded word is the stored result when `twos_sel`=0, and the stored result with its most significant bit inverted when `twos_sel`=1.
- R5: In serial mode the coded word leaves on `sdata` most significant bit first. Each 0-to-1 transition of `sclk_ext`, seen between two consecutive system clock edges, moves to the next bit, and the new bit appears after the system clock edge at which `sclk_ext` is first seen high. After 16 such pulses `sdata` stays low until the count is cleared.
- R6: The bit position advances only while `cs_n`, `rd_n` and `ser_mode`=0 inverted (serial mode) all allow it, that is `cs_n`=0, `rd_n`=0 and `ser_mode`=1. Pulses given with `rd_n` high do not move the position. No bit is lost or repeated whether `sclk_ext` idles low or high.
- R7: While `cs_n` is high the bit position is held at the first bit, so every new selection starts at the most significant bit.
- R8: The stored result changes only in a cycle with `conv_done` high, where it takes `conv_data`. Between strobes it stays stable, including while a new conversion runs.
- R9: `busy` rises in the cycle after `conv_start` and falls in the cycle after `conv_done`. If both arrive in the same cycle, `conv_done` wins. Reset leaves `busy` low and the stored result zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Conversion start pulse from the core |
| conv_done | input | 1 | Result-valid strobe from the core |
| conv_data | input | DATA_W | Offset-binary result from the core |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read enable |
| ser_mode | input | 1 | 0 parallel, 1 serial |
| swap_bytes | input | 1 | Reverse byte lanes on the parallel bus |
| twos_sel | input | 1 | 1 selects two's complement coding |
| sclk_ext | input | 1 | Host-supplied serial clock |
| dbus | output | DATA_W | Parallel data bus |
| dbus_oe | output | DATA_W | Per-bit output enable of the data bus |
| sdata | output | 1 | Serial data line |
| sdata_oe | output | 1 | Output enable of the serial line |
| busy | output | 1 | Conversion in progress |

## Verification
The bench builds the block with its default width of 16 bits, so a word is two byte lanes and a full serial transfer takes 16 host pulses. This keeps complete words, byte reversal and end-of-word behaviour short enough to check exhaustively on every cycle. A behavioural model predicts every output each cycle while the host clock idles low, idles high, is cut off by a deselect partway through a word, or pulses with the read strobe released. It also predicts the outputs across a result that is read while the next conversion runs.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic {
    PM_PARALLEL = 1'b0,
    PM_SERIAL   = 1'b1
  } port_mode_e;

  function automatic int unsigned cnt_width(input int unsigned bits);
    return $clog2(bits + 1);
  endfunction
endpackage

// File: rtl/rp_hold.sv
module rp_hold #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic [DATA_W-1:0] hold_q,
  output logic              busy_q
);
  logic [DATA_W-1:0] hold_d;
  logic              busy_d;
  logic              hold_en;

  assign hold_en = conv_done;

  always_comb begin
    hold_d = hold_q;
    if (hold_en) hold_d = conv_data;
    busy_d = busy_q;
    if (conv_done)       busy_d = 1'b0;
    else if (conv_start) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      busy_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/rp_format.sv
module rp_format #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] hold_word,
  input  logic              twos_sel,
  input  logic              swap_bytes,
  output logic [DATA_W-1:0] coded,
  output logic [DATA_W-1:0] par_word
);
  localparam int unsigned NLANE = DATA_W / LANE_W;

  always_comb begin
    coded = hold_word;
    coded[DATA_W-1] = hold_word[DATA_W-1] ^ twos_sel;
  end

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign par_word[i*LANE_W +: LANE_W] = swap_bytes ?
      coded[(NLANE-1-i)*LANE_W +: LANE_W] : coded[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/rp_serial.sv
module rp_serial #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_ext,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              ser_en,
  input  logic [DATA_W-1:0] word,
  output logic              bit_o,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic             sclk_q;
  logic             sclk_rise;
  logic             step_en;
  logic [CNT_W-1:0] cnt_d;
  logic [DATA_W-1:0] shifted;

  assign sclk_rise = sclk_ext & ~sclk_q;
  assign step_en   = ser_en & ~cs_n & ~rd_n & sclk_rise
                     & (bit_cnt < CNT_W'(DATA_W));

  always_comb begin
    cnt_d = bit_cnt;
    if (cs_n)         cnt_d = '0;
    else if (step_en) cnt_d = bit_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      bit_cnt <= '0;
    end else begin
      sclk_q  <= sclk_ext;
      bit_cnt <= cnt_d;
    end
  end

  assign shifted = word << bit_cnt;
  assign bit_o   = shifted[DATA_W-1];
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              ser_mode,
  input  logic              swap_bytes,
  input  logic              twos_sel,
  input  logic              sclk_ext,
  output logic [DATA_W-1:0] dbus,
  output logic [DATA_W-1:0] dbus_oe,
  output logic              sdata,
  output logic              sdata_oe,
  output logic              busy
);
  import rp_pkg::*;
  localparam int unsigned CNT_W = cnt_width(DATA_W);

  port_mode_e        mode;
  logic              rd_active;
  logic              par_on;
  logic              ser_on;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] coded;
  logic [DATA_W-1:0] par_word;
  logic              ser_bit;
  logic [CNT_W-1:0]  bit_cnt;

  assign mode      = port_mode_e'(ser_mode);
  assign rd_active = ~cs_n & ~rd_n;
  assign par_on    = rd_active & (mode == PM_PARALLEL);
  assign ser_on    = rd_active & (mode == PM_SERIAL);

  rp_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_start(conv_start),
    .conv_done (conv_done),
    .conv_data (conv_data),
    .hold_q    (hold_q),
    .busy_q    (busy)
  );

  rp_format #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_format (
    .hold_word (hold_q),
    .twos_sel  (twos_sel),
    .swap_bytes(swap_bytes),
    .coded     (coded),
    .par_word  (par_word)
  );

  rp_serial #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_serial (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_ext(sclk_ext),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .ser_en  (mode == PM_SERIAL),
    .word    (coded),
    .bit_o   (ser_bit),
    .bit_cnt (bit_cnt)
  );

  assign dbus     = par_on ? par_word : '0;
  assign dbus_oe  = {DATA_W{par_on}};
  assign sdata    = ser_on & ser_bit;
  assign sdata_oe = ser_on;
endmodule

// File: rtl/rp_checker.sv
module rp_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              conv_done,
  input logic              busy,
  input logic [DATA_W-1:0] dbus_oe,
  input logic              sdata_oe,
  input logic [DATA_W-1:0] hold_q,
  input logic [CNT_W-1:0]  bit_cnt
);
  a_r1_outputs_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (dbus_oe == '0 && !sdata_oe));

  a_r2_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    !((|dbus_oe) && sdata_oe));

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(DATA_W));

  a_r6_rd_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rd_n) |=> $stable(bit_cnt));

  a_r7_cs_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bit_cnt == '0));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(hold_q));

  a_r9_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !busy);
endmodule

bind adc_result_port rp_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .rd_n     (rd_n),
  .conv_done(conv_done),
  .busy     (busy),
  .dbus_oe  (dbus_oe),
  .sdata_oe (sdata_oe),
  .hold_q   (hold_q),
  .bit_cnt  (bit_cnt)
);

// File: tb/adc_result_port_tb.sv
module adc_result_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0, conv_done = 1'b0;
  logic [15:0] conv_data = '0;
  logic        cs_n = 1'b1, rd_n = 1'b1, ser_mode = 1'b0;
  logic        swap_bytes = 1'b0, twos_sel = 1'b0, sclk_ext = 1'b0;
  logic [15:0] dbus, dbus_oe;
  logic        sdata, sdata_oe, busy;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R9";
  bit finished = 1'b0;

  // behavioural reference state
  logic [15:0] m_hold;
  bit          m_busy, m_prev;
  int          m_cnt;

  always #4 clk = ~clk;

  adc_result_port u_dut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
    .conv_data(conv_data), .cs_n(cs_n), .rd_n(rd_n), .ser_mode(ser_mode),
    .swap_bytes(swap_bytes), .twos_sel(twos_sel), .sclk_ext(sclk_ext),
    .dbus(dbus), .dbus_oe(dbus_oe), .sdata(sdata), .sdata_oe(sdata_oe),
    .busy(busy)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold <= '0; m_busy <= 1'b0; m_prev <= 1'b0; m_cnt <= 0;
    end else begin
      if (conv_done) m_hold <= conv_data;
      if (conv_done) m_busy <= 1'b0;
      else if (conv_start) m_busy <= 1'b1;
      if (cs_n) m_cnt <= 0;
      else if (ser_mode && !rd_n && sclk_ext && !m_prev && m_cnt < 16)
        m_cnt <= m_cnt + 1;
      m_prev <= sclk_ext;
    end
  end

  task automatic cmp(string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic [15:0] w, par;
    bit pon, son, sb;
    w   = m_hold ^ (twos_sel ? 16'h8000 : 16'h0000);
    par = swap_bytes ? {w[7:0], w[15:8]} : w;
    pon = !cs_n && !rd_n && !ser_mode;
    son = !cs_n && !rd_n && ser_mode;
    sb  = son && (m_cnt < 16) && w[15 - (m_cnt < 16 ? m_cnt : 0)];
    cmp("dbus_oe", dbus_oe, pon ? 16'hFFFF : 16'h0000);
    cmp("dbus", dbus, pon ? par : 16'h0000);
    cmp("sdata_oe", {15'd0, sdata_oe}, {15'd0, son});
    cmp("sdata", {15'd0, sdata}, {15'd0, sb});
    cmp("busy", {15'd0, busy}, {15'd0, m_busy});
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      check_all();
    end
  endtask

  task automatic convert(logic [15:0] val, int gap);
    conv_start = 1'b1; tick(); conv_start = 1'b0;
    tick(gap);
    conv_data = val; conv_done = 1'b1; tick(); conv_done = 1'b0;
    tick();
  endtask

  task automatic pulses(int n, bit idle_high);
    for (int i = 0; i < n; i++) begin
      sclk_ext = ~idle_high; tick(2);
      sclk_ext = idle_high;  tick(2);
    end
  endtask

  initial begin
    tick(2);
    cur_req = "R9"; rst_n = 1'b1; tick(); // reset state
    convert(16'h1234, 3);
    cur_req = "R9"; conv_start = 1'b1; conv_done = 1'b1; conv_data = 16'h0F0F;
    tick(); conv_start = 1'b0; conv_done = 1'b0; tick(2);

    // parallel paths
    cur_req = "R2"; cs_n = 1'b0; rd_n = 1'b0; tick(2);
    cur_req = "R3"; swap_bytes = 1'b1; tick(2);
    convert(16'hA55A, 1);
    cur_req = "R4"; twos_sel = 1'b1; tick(2);
    swap_bytes = 1'b0; tick(2);
    cur_req = "R1"; rd_n = 1'b1; tick(2);
    rd_n = 1'b0; cs_n = 1'b1; tick(2);

    // serial, clock idling low
    cur_req = "R5"; ser_mode = 1'b1; twos_sel = 1'b0; cs_n = 1'b0; tick(2);
    pulses(18, 1'b0);
    cur_req = "R7"; cs_n = 1'b1; tick(2); cs_n = 1'b0; tick(2);
    cur_req = "R4"; twos_sel = 1'b1; pulses(3, 1'b0);
    cur_req = "R6"; rd_n = 1'b1; pulses(4, 1'b0); rd_n = 1'b0; tick(2);
    pulses(3, 1'b0);
    cur_req = "R7"; cs_n = 1'b1; tick(2);

    // serial, clock idling high
    cur_req = "R6"; sclk_ext = 1'b1; tick(3); twos_sel = 1'b0;
    convert(16'hC3E1, 2);
    cs_n = 1'b0; tick(3);
    pulses(17, 1'b1);
    cur_req = "R1"; cs_n = 1'b1; tick(2);

    // read during the next conversion
    cur_req = "R8"; ser_mode = 1'b0; cs_n = 1'b0; sclk_ext = 1'b0;
    conv_start = 1'b1; tick(); conv_start = 1'b0;
    conv_data = 16'hFFFF; tick(4);
    conv_data = 16'h8001; conv_done = 1'b1; tick(); conv_done = 1'b0; tick(3);
    cur_req = "R3"; swap_bytes = 1'b1; tick(2);
    cs_n = 1'b1; rd_n = 1'b1; tick(2);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule